// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single timer channel built around a 32-bit down-counter. A shared phase counter divides the peripheral clock by one of five powers of four. Each divided tick decrements the count while the enclosing unit holds the channel's start input high. When a tick finds the count at zero, the counter reloads from a reload register on that same tick and raises a sticky underflow flag. A level interrupt is raised while the flag is set and the interrupt enable bit is set.

Software sees four word-indexed registers through a single-cycle read and write port:

| Index | Register |
|---|---|
| 0 | reload |
| 1 | live count |
| 2 | control |
| 3 | optional spare capture register, which only stores a value |

The control word holds the following fields:

| Bits | Field |
|---|---|
| 2:0 | divider select |
| 4:3 | edge select (stored only) |
| 5 | interrupt enable |
| 7:6 | capture mode (stored only) |
| 8 | underflow flag |

Writing the control word restarts the divider phase, so that a new ratio begins from a clean boundary. Stopping the channel freezes both the count and the divider phase. The peripheral clock is modelled as a tick-enable input sampled on the system clock.

Top module: `tmr_channel`

## Requirements
- R1: After a synchronous reset, the reload and count registers read 0xFFFFFFFF, the control register reads 0, the capture register reads 0 and irq is low.
- R2: With divider select s in 0..4, the count decrements once every 4^(s+1) clock edges at which both start and tick_en are high, counted from the last control write. Edges with tick_en low do not advance the divider.
- R3: Divider select values 5, 6 and 7 produce no ticks, so the count holds while started.
- R4: A tick with count above zero decrements the count. A tick with count zero loads the reload value on that same edge.
- R5: A tick that finds the count at zero sets the underflow flag, which reads back in control bit 8. A set in the same cycle as a clearing write wins.
- R6: A control write with bit 8 = 0 clears the flag, and a control write with bit 8 = 1 leaves the flag unchanged. Every control write resets the divider phase.
- R7: irq is high exactly while the underflow flag and control bit 5 (interrupt enable) are both set.
- R8: With start low, the count and the divider phase hold. A later restart continues from the held phase and count.
- R9: A write to index 1 sets the count on that edge and takes priority over a tick. A write to index 0 leaves the count untouched, and a read of index 1 returns the live count.
- R10: A control read returns bits 7:0 as last written, the flag in bit 8, and zero in bits 31:9. Written bits 31:9 are discarded.
- R11: When HAS_CAPTURE is 1, index 3 stores and returns a full word. When it is 0, index 3 reads 0 and writes are ignored.
- R12: rdata is registered. It shows the addressed value one edge after rd_en and holds that value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Peripheral clock enable, one pulse per peripheral clock |
| start | input | 1 | Run enable from the enclosing unit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: underflow flag AND enable |

## Verification
A wrong divider phase or select decode shows up as a count that is off by whole ticks. This is visible on the first count read after a run of a few thousand edges, and a divider fault becomes an error of one or more ticks. A lost or spurious reload shows up on that same read as a count far from the arithmetic expectation. It also shows up as a wrong bit 8 and a wrong irq level. A phase that is not held across a stop shows up only when a run is split into two parts that each end short of a tick boundary. That case is therefore exercised explicitly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    IDX_RELOAD  = 2'd0,
    IDX_COUNT   = 2'd1,
    IDX_CTRL    = 2'd2,
    IDX_CAPTURE = 2'd3
  } reg_idx_e;

  localparam int SEL_W         = 3;
  localparam int NUM_DIVS      = 5;
  localparam int DIV_STEP_LOG  = 2;
  localparam int PHASE_W       = DIV_STEP_LOG * NUM_DIVS;
  localparam int CTRL_STORED_W = 8;
  localparam int CTRL_IE_BIT   = 5;
  localparam int CTRL_FLAG_BIT = 8;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int NUM_SEL = 2 ** SEL_W;

  logic [PHASE_W-1:0] phase_q;
  logic [NUM_SEL-1:0] hit;

  // Phase wraps at the largest divisor; each smaller divisor fires when
  // its low bits are all ones.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (advance) begin
      phase_q <= phase_q + PHASE_W'(1);
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SEL; gi++) begin : g_hit
      if (gi < NUM_DIVS) begin : g_legal
        assign hit[gi] = &phase_q[(gi+1)*DIV_STEP_LOG-1:0];
      end else begin : g_reserved
        assign hit[gi] = 1'b0;
      end
    end
  endgenerate

  assign tick = advance && hit[sel];

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt_q,
  output logic         underflow
);

  logic at_zero;
  assign at_zero   = (cnt_q == '0);
  assign underflow = tick && at_zero && !load_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
    end else if (load_en) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= at_zero ? reload_val : (cnt_q - W'(1));
    end
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W           = 32,
  parameter bit HAS_CAPTURE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     cnt_q,
  input  logic             underflow,
  output logic [W-1:0]     rdata,
  output logic [W-1:0]     reload_q,
  output logic [SEL_W-1:0] sel,
  output logic             ie,
  output logic             flag_q,
  output logic             ctrl_wr,
  output logic             cnt_wr
);

  reg_idx_e idx;
  assign idx = reg_idx_e'(addr);

  logic [CTRL_STORED_W-1:0] ctrl_q;
  logic [W-1:0]             capture_q;
  logic                     reload_wr;
  logic                     capture_wr;

  assign reload_wr  = wr_en && (idx == IDX_RELOAD);
  assign cnt_wr     = wr_en && (idx == IDX_COUNT);
  assign ctrl_wr    = wr_en && (idx == IDX_CTRL);
  assign capture_wr = wr_en && (idx == IDX_CAPTURE);

  assign sel = ctrl_q[SEL_W-1:0];
  assign ie  = ctrl_q[CTRL_IE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
    end else if (reload_wr) begin
      reload_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata[CTRL_STORED_W-1:0];
    end
  end

  // Set from an underflow outranks a clearing write in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (underflow) begin
      flag_q <= 1'b1;
    end else if (ctrl_wr && !wdata[CTRL_FLAG_BIT]) begin
      flag_q <= 1'b0;
    end
  end

  generate
    if (HAS_CAPTURE) begin : g_cap
      always_ff @(posedge clk) begin
        if (rst) begin
          capture_q <= '0;
        end else if (capture_wr) begin
          capture_q <= wdata;
        end
      end
    end else begin : g_nocap
      assign capture_q = '0;
    end
  endgenerate

  logic [W-1:0] rd_mux;
  always_comb begin
    unique case (idx)
      IDX_RELOAD:  rd_mux = reload_q;
      IDX_COUNT:   rd_mux = cnt_q;
      IDX_CTRL:    rd_mux = W'({flag_q, ctrl_q});
      IDX_CAPTURE: rd_mux = capture_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W           = 32,
  parameter bit HAS_CAPTURE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         start,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);

  logic [W-1:0]     cnt_q;
  logic [W-1:0]     reload_q;
  logic [SEL_W-1:0] sel;
  logic             ie;
  logic             flag_q;
  logic             ctrl_wr;
  logic             cnt_wr;
  logic             tick;
  logic             underflow;

  tmr_regs #(.W(W), .HAS_CAPTURE(HAS_CAPTURE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cnt_q     (cnt_q),
    .underflow (underflow),
    .rdata     (rdata),
    .reload_q  (reload_q),
    .sel       (sel),
    .ie        (ie),
    .flag_q    (flag_q),
    .ctrl_wr   (ctrl_wr),
    .cnt_wr    (cnt_wr)
  );

  tmr_prescaler u_psc (
    .clk     (clk),
    .rst     (rst),
    .restart (ctrl_wr),
    .advance (start && tick_en),
    .sel     (sel),
    .tick    (tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .load_en    (cnt_wr),
    .load_val   (wdata),
    .reload_val (reload_q),
    .cnt_q      (cnt_q),
    .underflow  (underflow)
  );

  assign irq = flag_q && ie;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [W-1:0]     wdata,
  input logic             irq,
  input logic             tick,
  input logic [W-1:0]     cnt_q,
  input logic [W-1:0]     reload_q,
  input logic             flag_q,
  input logic [SEL_W-1:0] sel
);

  logic cnt_write;
  logic ctrl_clear;
  assign cnt_write  = wr_en && (addr == 2'd1);
  assign ctrl_clear = wr_en && (addr == 2'd2) && !wdata[CTRL_FLAG_BIT];

  assert_hold_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (!start && !cnt_write) |=> $stable(cnt_q));

  assert_count_write_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_write |=> (cnt_q == $past(wdata)));

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == '0 && !cnt_write) |=> (cnt_q == $past(reload_q) && flag_q));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ctrl_clear) |=> flag_q);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
    !flag_q |-> !irq);

  assert_no_reserved_tick_R3: assert property (@(posedge clk) disable iff (rst)
    tick |-> (sel < SEL_W'(NUM_DIVS)));

  assert_tick_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> start);

endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .irq      (irq),
  .tick     (tick),
  .cnt_q    (cnt_q),
  .reload_q (reload_q),
  .flag_q   (flag_q),
  .sel      (sel)
);

// File: tb/tmr_channel_bench.sv
`timescale 1ns/1ps
module tmr_channel_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b1;
  logic        start = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_channel u_tmr_channel (
    .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic run(input int k);
    @(negedge clk); start = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk); start = 1'b0;
  endtask

  function automatic logic [31:0] exp_cnt(input longint c0, input longint l, input longint t);
    if (t <= c0) return 32'(c0 - t);
    return 32'(l - ((t - c0 - 1) % (l + 1)));
  endfunction

  function automatic longint exp_uf(input longint c0, input longint l, input longint t);
    if (t <= c0) return 0;
    return 1 + (t - c0 - 1) / (l + 1);
  endfunction

  // Configure, run k started edges, then compare count, flag and irq.
  task automatic sweep_case(input int sel, input longint c0, input longint l,
                            input int k, input bit ie);
    logic [31:0] d;
    longint div, t, uf;
    div = longint'(1) << (2 * (sel + 1));
    t   = (sel <= 4) ? (k / div) : 0;
    uf  = exp_uf(c0, l, t);
    wr(2'd0, 32'(l));
    wr(2'd1, 32'(c0));
    wr(2'd2, {26'd0, ie, 2'b00, 3'(sel)});
    run(k);
    rd(2'd1, d);
    chk((sel <= 4) ? "R2/R4 count after run" : "R3 reserved select holds count", d, exp_cnt(c0, l, t));
    rd(2'd2, d);
    chk("R5 flag in ctrl read", d, {23'd0, (uf > 0), 2'b00, ie, 2'b00, 3'(sel)});
    chk("R7 irq level", {31'd0, irq}, {31'd0, (uf > 0) && ie});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(2'd0, d); chk("R1 reload reset", d, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R1 count reset", d, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R1 ctrl reset", d, 32'd0);
    rd(2'd3, d); chk("R1 capture reset", d, 32'd0);

    // R2 from reset values: select 0 divides by 4
    run(13);
    rd(2'd1, d); chk("R2 div4 from reset count", d, 32'hFFFF_FFFC);

    // R2 R3 R4 R5 R7 sweep over every select value
    for (int s = 0; s < 8; s++) begin
      int div = 1 << (2 * (s + 1));
      int k1 = (s <= 4) ? (div * 7 + div / 2) : 100;
      int k2 = (s <= 4) ? (div * (3 + s) + 1) : 37;
      sweep_case(s, 3, 2, k1, 1'b1);
      sweep_case(s, s, 5, k2, s[0]);
    end
    sweep_case(0, 0, 0, 24, 1'b1);   // R4 reload of zero every tick

    // R6 flag clear semantics
    sweep_case(0, 1, 3, 12, 1'b1);   // three ticks -> one underflow
    wr(2'd2, 32'h0000_0120);
    rd(2'd2, d); chk("R6 write 1 to flag keeps it", d, 32'h0000_0120);
    chk("R7 irq still high", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h0000_0000);
    rd(2'd2, d); chk("R6 write 0 to flag clears it", d, 32'd0);
    chk("R7 irq low with no enable", {31'd0, irq}, 32'd0);

    // R6 control write resets phase: 3 edges, rewrite ctrl, 3 edges -> no tick
    wr(2'd1, 32'd50);
    wr(2'd2, 32'd0);
    run(3);
    wr(2'd2, 32'd0);
    run(3);
    rd(2'd1, d); chk("R6 ctrl write restarts divider", d, 32'd50);

    // R8 stop/restart keeps phase: 10 + 10 edges at div16 -> one tick
    wr(2'd1, 32'd50);
    wr(2'd2, 32'd1);
    run(10);
    repeat (5) @(negedge clk);
    rd(2'd1, d); chk("R8 count held while stopped", d, 32'd50);
    run(10);
    rd(2'd1, d); chk("R8 phase held across stop", d, 32'd49);

    // R2 tick_en gating: 40 edges, 20 enabled, div4 -> 5 ticks
    wr(2'd1, 32'd100);
    wr(2'd2, 32'd0);
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick_en = (i % 2 == 0);
      @(negedge clk);
    end
    start = 1'b0; tick_en = 1'b1;
    rd(2'd1, d); chk("R2 tick_en gates divider", d, 32'd95);

    // R9 count write, reload write leaves count alone
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, d); chk("R9 count write", d, 32'h1234_5678);
    wr(2'd0, 32'h0000_0AAA);
    rd(2'd1, d); chk("R9 reload write leaves count", d, 32'h1234_5678);
    rd(2'd0, d); chk("R9 reload readback", d, 32'h0000_0AAA);

    // R10 reserved control bits discarded
    wr(2'd2, 32'hFFFF_FEFF);
    rd(2'd2, d); chk("R10 ctrl upper bits read zero", d, 32'h0000_00FF);
    wr(2'd2, 32'd0);

    // R11 capture register
    wr(2'd3, 32'hCAFE_0042);
    rd(2'd3, d); chk("R11 capture readback", d, 32'hCAFE_0042);

    // R12 rdata holds without rd_en
    rd(2'd0, d);
    wr(2'd1, 32'd7);
    run(20);
    repeat (3) @(negedge clk);
    chk("R12 rdata holds", rdata, 32'h0000_0AAA);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule